// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a processor three 8-bit parallel ports, named A, B and C, with port C handled as two 4-bit halves. The processor reaches it through a small register interface: an active-low select, active-low read and write strobes, a two-bit register address and a split 8-bit data path with a read-enable flag in place of a shared three-state bus. Each port pin group is either an input, whose pins are sampled on a read, or an output, driven from a latch that keeps the last value written.

A single configuration address does two jobs. With data bit 7 high it takes a full configuration word that sets the direction of port A, port B and each half of port C, and records mode fields that are stored but do not alter the simple I/O behaviour. With bit 7 low it takes a command that sets or clears one bit of the port C latch without touching the configuration. Group A covers port A and the upper half of port C; group B covers port B and the lower half.

Top module: `parIoTop`

## Requirements
- R1: With `csN` high no register is read or written and `dataOe` stays low, whatever the strobes do.
- R2: With `csN` and `rdN` low and `wrN` high, `dataOe` is high and `dataOut` shows the register picked by `addr`: 0 port A, 1 port B, 2 port C, 3 configuration.
- R3: A write to address 3 with data bit 7 = 1 is a configuration word: bit 4 is port A direction, bit 3 port C upper direction, bit 1 port B direction, bit 0 port C lower direction, 1 meaning input; bits 6:5 and 2 are stored mode fields. Each group's output-enable vector is all ones when its direction bit is 0 and all zeros when it is 1.
- R4: Reading address 3 returns the stored configuration word with bit 7 set to 1.
- R5: A write to address 3 with data bit 7 = 0 writes data bit 0 into the port C latch bit whose index is data bits 3:1; bits 6:4 have no effect, no other latch bit changes, and the configuration and output enables stay as they were.
- R6: The two halves of port C have independent directions; a port C read returns the latch for each half set to output and the pins for each half set to input.
- R7: A write to address 0, 1 or 2 loads the data into that port's latch, which drives its output pins until changed; a read of a port set to input returns its pin values.
- R8: While `rst` is high (synchronous, active high) the configuration returns to all-input with zero mode fields (reads back as 0x9B), every latch clears to 0 and every output enable is 0.
- R9: A write takes effect at the first clock edge at which `wrN` is sampled low; keeping `wrN` low for more edges performs no further write even if the data changes.
- R10: A configuration word write clears the latches of all three ports to 0.
- R11: When `rdN` and `wrN` are both low, nothing is written and `dataOe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| dataIn | input | 8 | Write data from the processor |
| dataOut | output | 8 | Read data to the processor |
| dataOe | output | 1 | High while `dataOut` should be driven onto the bus |
| aPinIn | input | 8 | Port A pin values |
| aPinOut | output | 8 | Port A latch driving the pins |
| aPinOe | output | 8 | Port A per-bit output enable |
| bPinIn | input | 8 | Port B pin values |
| bPinOut | output | 8 | Port B latch driving the pins |
| bPinOe | output | 8 | Port B per-bit output enable |
| cPinIn | input | 8 | Port C pin values |
| cPinOut | output | 8 | Port C latch driving the pins |
| cPinOe | output | 8 | Port C per-bit output enable |

## Verification
On every cycle the assertions check that the data path is never driven when the block is deselected or both strobes are low, that configuration reads carry bit 7 set, that reset leaves every pin undriven, that a held write strobe changes no latch after its first edge, that a bit command keeps every output enable, and that a configuration word leaves all latches at zero. The bench's scenarios are what show that each of the sixteen direction combinations produces the right enables and read data, that every port C bit index is set and cleared alone, and that the per-half read mux picks latch or pins correctly; these depend on exact values that the properties do not compute.

// File: rtl/parIoPkg.sv
package parIoPkg;
  localparam int PORT_W = 8;
  localparam int NIB_W = 4;
  localparam int NUM_NIB = PORT_W / NIB_W;
  localparam int IDX_W = $clog2(PORT_W);

  // configuration word bit positions (decoded by the datapath)
  localparam int CFG_SEL_BIT = 7;
  localparam int DIR_A_BIT = 4;
  localparam int DIR_CHI_BIT = 3;
  localparam int DIR_B_BIT = 1;
  localparam int DIR_CLO_BIT = 0;
  localparam int CFG_W = PORT_W - 1;

  // all four direction bits set to input, mode fields zero
  localparam logic [CFG_W-1:0] CFG_RESET =
    CFG_W'((1 << DIR_A_BIT) | (1 << DIR_CHI_BIT) | (1 << DIR_B_BIT) | (1 << DIR_CLO_BIT));

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CFG = 2'b11
  } regSel_t;

  typedef struct packed {
    logic wrA;
    logic wrB;
    logic wrC;
    logic wrCfg;
    logic wrBit;
    logic [PORT_W-1:0] data;
  } busStrobe_t;
endpackage

// File: rtl/parIoCtrl.sv
module parIoCtrl
  import parIoPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] dataIn,
  output busStrobe_t        strobe,
  output logic              rdEn,
  output regSel_t           rdSel
);
  logic wrLowQ;
  logic access;
  logic wrFire;
  regSel_t sel;

  // remembers that the write strobe was already low at the previous edge
  always_ff @(posedge clk) begin
    if (rst) wrLowQ <= 1'b0;
    else     wrLowQ <= !wrN;
  end

  always_comb begin
    sel    = regSel_t'(addr);
    access = !csN;
    wrFire = access && !wrN && rdN && !wrLowQ;
    rdEn   = access && !rdN && wrN;
    rdSel  = sel;

    strobe       = '0;
    strobe.data  = dataIn;
    strobe.wrA   = wrFire && (sel == SEL_A);
    strobe.wrB   = wrFire && (sel == SEL_B);
    strobe.wrC   = wrFire && (sel == SEL_C);
    strobe.wrCfg = wrFire && (sel == SEL_CFG) && dataIn[CFG_SEL_BIT];
    strobe.wrBit = wrFire && (sel == SEL_CFG) && !dataIn[CFG_SEL_BIT];
  end
endmodule

// File: rtl/parIoData.sv
module parIoData
  import parIoPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  busStrobe_t        strobe,
  input  logic              rdEn,
  input  regSel_t           rdSel,
  output logic [PORT_W-1:0] dataOut,
  output logic              dataOe,
  input  logic [PORT_W-1:0] aPinIn,
  output logic [PORT_W-1:0] aPinOut,
  output logic [PORT_W-1:0] aPinOe,
  input  logic [PORT_W-1:0] bPinIn,
  output logic [PORT_W-1:0] bPinOut,
  output logic [PORT_W-1:0] bPinOe,
  input  logic [PORT_W-1:0] cPinIn,
  output logic [PORT_W-1:0] cPinOut,
  output logic [PORT_W-1:0] cPinOe
);
  logic [CFG_W-1:0]  cfgQ;
  logic [PORT_W-1:0] latA, latB, latC;
  logic [PORT_W-1:0] rdA, rdB, rdC;
  logic [IDX_W-1:0]  bitIdx;
  logic              bitVal;

  assign bitIdx = strobe.data[IDX_W:1];
  assign bitVal = strobe.data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ <= CFG_RESET;
    end else if (strobe.wrCfg) begin
      cfgQ <= strobe.data[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.wrCfg) begin
      latA <= '0;
      latB <= '0;
    end else begin
      if (strobe.wrA) latA <= strobe.data;
      if (strobe.wrB) latB <= strobe.data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.wrCfg) begin
      latC <= '0;
    end else if (strobe.wrC) begin
      latC <= strobe.data;
    end else if (strobe.wrBit) begin
      latC[bitIdx] <= bitVal;
    end
  end

  // ports A and B: whole-port direction
  assign rdA    = cfgQ[DIR_A_BIT] ? aPinIn : latA;
  assign rdB    = cfgQ[DIR_B_BIT] ? bPinIn : latB;
  assign aPinOe = {PORT_W{!cfgQ[DIR_A_BIT]}};
  assign bPinOe = {PORT_W{!cfgQ[DIR_B_BIT]}};

  // port C: each half has its own direction bit
  for (genvar g = 0; g < NUM_NIB; g++) begin : gCHalf
    localparam int DBIT = (g == 0) ? DIR_CLO_BIT : DIR_CHI_BIT;
    logic isIn;
    assign isIn = cfgQ[DBIT];
    assign rdC[g*NIB_W +: NIB_W]    = isIn ? cPinIn[g*NIB_W +: NIB_W] : latC[g*NIB_W +: NIB_W];
    assign cPinOe[g*NIB_W +: NIB_W] = {NIB_W{!isIn}};
  end

  assign aPinOut = latA;
  assign bPinOut = latB;
  assign cPinOut = latC;

  always_comb begin
    unique case (rdSel)
      SEL_A:   dataOut = rdA;
      SEL_B:   dataOut = rdB;
      SEL_C:   dataOut = rdC;
      default: dataOut = {1'b1, cfgQ};
    endcase
  end

  assign dataOe = rdEn;
endmodule

// File: rtl/parIoTop.sv
module parIoTop
  import parIoPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [1:0] addr,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic       dataOe,
  input  logic [7:0] aPinIn,
  output logic [7:0] aPinOut,
  output logic [7:0] aPinOe,
  input  logic [7:0] bPinIn,
  output logic [7:0] bPinOut,
  output logic [7:0] bPinOe,
  input  logic [7:0] cPinIn,
  output logic [7:0] cPinOut,
  output logic [7:0] cPinOe
);
  busStrobe_t strobe;
  logic       rdEn;
  regSel_t    rdSel;

  parIoCtrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .csN    (csN),
    .rdN    (rdN),
    .wrN    (wrN),
    .addr   (addr),
    .dataIn (dataIn),
    .strobe (strobe),
    .rdEn   (rdEn),
    .rdSel  (rdSel)
  );

  parIoData u_data (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .rdEn    (rdEn),
    .rdSel   (rdSel),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .aPinIn  (aPinIn),
    .aPinOut (aPinOut),
    .aPinOe  (aPinOe),
    .bPinIn  (bPinIn),
    .bPinOut (bPinOut),
    .bPinOe  (bPinOe),
    .cPinIn  (cPinIn),
    .cPinOut (cPinOut),
    .cPinOe  (cPinOe)
  );
endmodule

// File: rtl/parIoChecks.sv
module parIoChecks (
  input logic       clk,
  input logic       rst,
  input logic       csN,
  input logic       rdN,
  input logic       wrN,
  input logic [1:0] addr,
  input logic [7:0] dataIn,
  input logic [7:0] dataOut,
  input logic       dataOe,
  input logic [7:0] aPinOut,
  input logic [7:0] aPinOe,
  input logic [7:0] bPinOut,
  input logic [7:0] bPinOe,
  input logic [7:0] cPinOut,
  input logic [7:0] cPinOe
);
  logic heldLow;
  logic firstEdge;

  always_ff @(posedge clk) begin
    if (rst) heldLow <= 1'b0;
    else     heldLow <= !wrN;
  end

  assign firstEdge = !csN && !wrN && rdN && !heldLow && (addr == 2'b11);

  a_r1_no_drive_deselected: assert property (@(posedge clk) disable iff (rst)
    csN |-> !dataOe);

  a_r11_no_drive_both_low: assert property (@(posedge clk) disable iff (rst)
    (!rdN && !wrN) |-> !dataOe);

  a_r4_cfg_read_top_bit: assert property (@(posedge clk) disable iff (rst)
    (dataOe && addr == 2'b11) |-> dataOut[7]);

  a_r8_reset_releases_pins: assert property (@(posedge clk)
    rst |=> (aPinOe == 8'h00 && bPinOe == 8'h00 && cPinOe == 8'h00));

  a_r9_held_strobe_no_rewrite: assert property (@(posedge clk) disable iff (rst)
    (!wrN && heldLow) |=> ($stable(aPinOut) && $stable(bPinOut) && $stable(cPinOut)
                           && $stable(aPinOe) && $stable(cPinOe)));

  a_r5_bit_cmd_keeps_dirs: assert property (@(posedge clk) disable iff (rst)
    (firstEdge && !dataIn[7]) |=> ($stable(aPinOe) && $stable(bPinOe) && $stable(cPinOe)
                                   && $stable(aPinOut) && $stable(bPinOut)));

  a_r10_cfg_clears_latches: assert property (@(posedge clk) disable iff (rst)
    (firstEdge && dataIn[7]) |=> (aPinOut == 8'h00 && bPinOut == 8'h00 && cPinOut == 8'h00));
endmodule

bind parIoTop parIoChecks u_chk (
  .clk     (clk),
  .rst     (rst),
  .csN     (csN),
  .rdN     (rdN),
  .wrN     (wrN),
  .addr    (addr),
  .dataIn  (dataIn),
  .dataOut (dataOut),
  .dataOe  (dataOe),
  .aPinOut (aPinOut),
  .aPinOe  (aPinOe),
  .bPinOut (bPinOut),
  .bPinOe  (bPinOe),
  .cPinOut (cPinOut),
  .cPinOe  (cPinOe)
);

// File: tb/sim_parIoTop.sv
`timescale 1ns/100ps
module sim_parIoTop;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic       dataOe;
  logic [7:0] aPinIn = 8'hC3, bPinIn = 8'h3C, cPinIn = 8'hA5;
  logic [7:0] aPinOut, aPinOe, bPinOut, bPinOe, cPinOut, cPinOe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = !clk;

  parIoTop u0 (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .aPinIn(aPinIn), .aPinOut(aPinOut), .aPinOe(aPinOe),
    .bPinIn(bPinIn), .bPinOut(bPinOut), .bPinOe(bPinOe),
    .cPinIn(cPinIn), .cPinOut(cPinOut), .cPinOe(cPinOe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; addr = a; dataIn = d;
    @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addr = a;
    #1;
    v = dataOut; oe = dataOe;
    rdN = 1'b1; csN = 1'b1;
  endtask

  task automatic checkReset(input string tag);
    logic [7:0] v; logic oe;
    check({tag, " R8 aOe"}, aPinOe, 8'h00);
    check({tag, " R8 bOe"}, bPinOe, 8'h00);
    check({tag, " R8 cOe"}, cPinOe, 8'h00);
    check({tag, " R8 latches"}, {aPinOut, bPinOut, cPinOut}, 24'h0);
    busRead(2'b11, v, oe);
    check({tag, " R8 R4 cfg readback"}, v, 8'h9B);
    check({tag, " R2 read oe"}, oe, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, word, expC, valA, valB, valC;
    logic oe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkReset("initial");

    // sweep every direction combination with varying mode fields
    for (int m = 0; m < 16; m++) begin
      word = 8'h80 | 8'((m % 4) << 5) | 8'(m[3] << 4) | 8'(m[2] << 3)
             | 8'(((m >> 2) & 1) << 2) | 8'(m[1] << 1) | 8'(m[0]);
      busWrite(2'b11, word);
      check("R10 latches cleared", {aPinOut, bPinOut, cPinOut}, 24'h0);
      check("R3 aOe", aPinOe, m[3] ? 8'h00 : 8'hFF);
      check("R3 bOe", bPinOe, m[1] ? 8'h00 : 8'hFF);
      check("R6 cOe", cPinOe, {m[2] ? 4'h0 : 4'hF, m[0] ? 4'h0 : 4'hF});
      busRead(2'b11, v, oe);
      check("R4 cfg readback", v, word);
      valA = 8'h5A ^ 8'(m);
      valB = 8'h96 + 8'(m);
      valC = 8'h0F ^ 8'(m << 4) ^ 8'(m);
      busWrite(2'b00, valA);
      busWrite(2'b01, valB);
      busWrite(2'b10, valC);
      check("R7 aOut", aPinOut, valA);
      check("R7 bOut", bPinOut, valB);
      check("R7 cOut", cPinOut, valC);
      busRead(2'b00, v, oe);
      check("R7 R2 read A", v, m[3] ? aPinIn : valA);
      busRead(2'b01, v, oe);
      check("R7 R2 read B", v, m[1] ? bPinIn : valB);
      busRead(2'b10, v, oe);
      check("R6 read C", v, {m[2] ? cPinIn[7:4] : valC[7:4], m[0] ? cPinIn[3:0] : valC[3:0]});
      aPinIn = aPinIn + 8'h11;
      cPinIn = {cPinIn[6:0], cPinIn[7]};
    end

    // single-bit commands on port C, with junk in bits 6:4
    busWrite(2'b11, 8'h80);
    expC = 8'h00;
    for (int i = 0; i < 8; i++) begin
      busWrite(2'b11, {1'b0, 3'(7 - i), 3'(i), 1'b1});
      expC[i] = 1'b1;
      check("R5 bit set", cPinOut, expC);
      check("R5 oe kept", {aPinOe, bPinOe, cPinOe}, 24'hFFFFFF);
    end
    for (int i = 0; i < 8; i++) begin
      busWrite(2'b11, {1'b0, 3'(i), 3'(i), 1'b0});
      expC[i] = 1'b0;
      check("R5 bit clear", cPinOut, expC);
    end
    busRead(2'b11, v, oe);
    check("R5 cfg unchanged", v, 8'h80);

    // held write strobe with changing data: one write
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; addr = 2'b00; dataIn = 8'h11;
    @(negedge clk); dataIn = 8'h22;
    @(negedge clk); dataIn = 8'h33;
    @(negedge clk); wrN = 1'b1; csN = 1'b1;
    check("R9 held strobe", aPinOut, 8'h11);
    busWrite(2'b00, 8'h44);
    check("R9 next write", aPinOut, 8'h44);

    // deselected access
    @(negedge clk);
    csN = 1'b1; wrN = 1'b0; addr = 2'b00; dataIn = 8'h99;
    @(negedge clk); wrN = 1'b1; rdN = 1'b0;
    #1 check("R1 no drive deselected", dataOe, 1'b0);
    rdN = 1'b1;
    @(negedge clk);
    check("R1 no write deselected", aPinOut, 8'h44);

    // both strobes low
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; wrN = 1'b0; addr = 2'b00; dataIn = 8'h77;
    #1 check("R11 no drive both low", dataOe, 1'b0);
    @(negedge clk);
    rdN = 1'b1; wrN = 1'b1; csN = 1'b1;
    @(negedge clk);
    check("R11 no write both low", aPinOut, 8'h44);

    // reset during operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    checkReset("midrun");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule